// File: doc/BRIEF.md
# Bus Wake Pattern Detector

This block watches the bus level seen by a low-power receiver while the transceiver sits in standby. It decides whether the remote node has sent a genuine wake request. A single burst of bus activity is not enough. The bus has to show three phases in order: a dominant phase, then a recessive phase, then another dominant phase. Each phase has to last a minimum number of clock cycles, and the whole sequence has to finish inside a bounded window. A phase that is too short, or a window that runs out, throws the partial progress away and the detector waits for a fresh dominant phase.

The bus input is asynchronous and passes through a two-flop synchronizer before any timing is applied. Until a wake is recognised, the receive output is held high. Once a wake is confirmed, a latched wake flag is raised and the receive output follows the synchronized bus level. The output is low while the bus is dominant and high while it is recessive. The standby enable clears everything when it drops, which happens on the move to normal mode. The minimum phase length and the window length are parameters in clock cycles.

Top module: `wake_pattern_detector`

## Requirements
- R1: Only the ordered sequence dominant, recessive, dominant can produce a wake. A single dominant stretch, however long, never raises `wake_flag`. On `bus_dom_raw`, 1 means dominant and 0 means recessive.
- R2: Every phase must contain at least `FILT_CYC` synchronized samples. A third phase of exactly `FILT_CYC` dominant samples raises `wake_flag`, while one of `FILT_CYC-1` samples does not.
- R3: A first dominant phase or a recessive phase shorter than `FILT_CYC` samples discards the progress made so far, and no wake follows from that attempt.
- R4: A dominant level that ends a too-short recessive phase starts a new attempt, and the window timer restarts from that sample.
- R5: `rx_out` is 1 whenever `wake_flag` is 0, including while the bus is dominant during an attempt.
- R6: While `wake_flag` is 1, `rx_out` equals the inverse of the synchronized bus level. A change on `bus_dom_raw` reaches `rx_out` after two rising clock edges.
- R7: Once raised, `wake_flag` stays at 1 for as long as `stby_en` stays high, whatever the bus does.
- R8: With `stby_en` low, `wake_flag` is 0 and `rx_out` is 1 from the next edge onward. A complete, valid pattern presented while `stby_en` is low produces no wake.
- R9: Number the synchronized samples of an attempt from 0, starting at its first dominant sample. The last required dominant sample must have an index below `TMO_CYC`. Otherwise the attempt is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Detector clock |
| rst | input | 1 | Synchronous active-high reset |
| stby_en | input | 1 | High while the transceiver is in standby; low clears the detector |
| bus_dom_raw | input | 1 | Asynchronous low-power receiver output, 1 = dominant |
| wake_flag | output | 1 | Latched wake indication |
| rx_out | output | 1 | Receive output: high before wake, inverse of bus level after wake |

## Verification
The bench targets the exact filter boundary on the third phase, with `FILT_CYC` dominant samples against `FILT_CYC-1`. A design that counts one sample too many or too few either misses the genuine wake or accepts a glitch. It drives window patterns whose last dominant sample lands at index `TMO_CYC-1` and at `TMO_CYC`, which exposes an off-by-one in the window check or a window that starts at the wrong sample. A short recessive phase followed by a fresh valid sequence shows whether the timer and phase progress restart on the new dominant level; a design that kept stale progress would wake too early or time out wrongly. Single long dominant pulses, short first phases and patterns sent while disabled check that no path raises the flag without the full ordered pattern.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    // Bus level encoding after synchronization.
    localparam logic LVL_DOM = 1'b1;
    localparam logic LVL_REC = 1'b0;

    // Sequencer states: waiting, first dominant, recessive gap, last dominant, woken.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_GAP   = 3'd2,
        ST_TAIL  = 3'd3,
        ST_AWAKE = 3'd4
    } wake_state_e;

    // Information about the current run of equal bus samples.
    typedef struct packed {
        logic change;     // current sample differs from the previous one
        logic prev_qual;  // run that just ended reached the filter length
        logic next_qual;  // current run, including this sample, reaches the filter length
    } run_info_t;

    // Control from the sequencer to the attempt window timer.
    typedef struct packed {
        logic start;      // a new attempt begins with this sample
        logic run;        // an attempt continues after this sample
    } window_ctl_t;

    function automatic logic in_attempt(wake_state_e s);
        return (s == ST_LEAD) || (s == ST_GAP) || (s == ST_TAIL);
    endfunction

endpackage

// File: rtl/bwd_sync.sv
module bwd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= bwd_pkg::LVL_REC;
                    else     chain[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= bwd_pkg::LVL_REC;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bwd_run_timer.sv
module bwd_run_timer
    import bwd_pkg::*;
#(
    parameter int FILT_CYC = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      level,
    output run_info_t info
);
    localparam int W = $clog2(FILT_CYC + 1);
    localparam logic [W:0] FILT_X = (W+1)'(FILT_CYC);

    logic         prev_lvl;
    logic [W-1:0] run_cnt;
    logic [W:0]   run_ext;

    assign run_ext        = {1'b0, run_cnt};
    assign info.change    = (level != prev_lvl);
    assign info.prev_qual = (run_ext >= FILT_X);
    assign info.next_qual = !info.change && ((run_ext + 1'b1) >= FILT_X);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            prev_lvl <= LVL_REC;
            run_cnt  <= '0;
        end else begin
            prev_lvl <= level;
            if (info.change)
                run_cnt <= W'(1);
            else if (run_ext < FILT_X)
                run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bwd_window_timer.sv
module bwd_window_timer
    import bwd_pkg::*;
#(
    parameter int TMO_CYC = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  window_ctl_t ctl,
    output logic        expired
);
    localparam int W = $clog2(TMO_CYC + 1);
    localparam logic [W-1:0] TMO_W = W'(TMO_CYC);

    logic [W-1:0] cnt;

    assign expired = (cnt >= TMO_W);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ctl.start) begin
            cnt <= W'(1);
        end else if (!ctl.run) begin
            cnt <= '0;
        end else if (cnt != TMO_W) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bwd_seq_fsm.sv
module bwd_seq_fsm
    import bwd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        level,
    input  run_info_t   info,
    input  logic        expired,
    output wake_state_e state,
    output window_ctl_t win,
    output logic        abort
);
    wake_state_e nxt;

    always_comb begin
        nxt       = state;
        win.start = 1'b0;
        abort     = 1'b0;
        if (!enable) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (level == LVL_DOM) begin
                        nxt       = ST_LEAD;
                        win.start = 1'b1;
                    end
                end
                ST_LEAD, ST_GAP, ST_TAIL: begin
                    if (expired) begin
                        nxt   = ST_IDLE;
                        abort = 1'b1;
                    end else if (state == ST_LEAD) begin
                        if (info.change)
                            nxt = info.prev_qual ? ST_GAP : ST_IDLE;
                    end else if (state == ST_GAP) begin
                        if (info.change) begin
                            if (info.prev_qual) begin
                                nxt = ST_TAIL;
                            end else begin
                                nxt       = ST_LEAD;
                                win.start = 1'b1;
                            end
                        end
                    end else begin
                        if (info.change)
                            nxt = ST_IDLE;
                        else if (info.next_qual)
                            nxt = ST_AWAKE;
                    end
                end
                ST_AWAKE: nxt = ST_AWAKE;
                default:  nxt = ST_IDLE;
            endcase
        end
        win.run = in_attempt(nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/wake_pattern_detector.sv
module wake_pattern_detector
    import bwd_pkg::*;
#(
    parameter int FILT_CYC    = 16,
    parameter int TMO_CYC     = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic stby_en,
    input  logic bus_dom_raw,
    output logic wake_flag,
    output logic rx_out
);
    logic        bus_s;
    run_info_t   info;
    window_ctl_t win;
    logic        expired;
    logic        abort;
    wake_state_e state;

    bwd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_dom_raw),
        .q   (bus_s)
    );

    bwd_run_timer #(.FILT_CYC(FILT_CYC)) u_run (
        .clk   (clk),
        .rst   (rst),
        .clr   (!stby_en || abort),
        .level (bus_s),
        .info  (info)
    );

    bwd_window_timer #(.TMO_CYC(TMO_CYC)) u_win (
        .clk     (clk),
        .rst     (rst),
        .ctl     (win),
        .expired (expired)
    );

    bwd_seq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .enable  (stby_en),
        .level   (bus_s),
        .info    (info),
        .expired (expired),
        .state   (state),
        .win     (win),
        .abort   (abort)
    );

    assign wake_flag = (state == ST_AWAKE);
    assign rx_out    = wake_flag ? ~bus_s : 1'b1;
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic bus_sync,
    input logic wake_flag,
    input logic rx_out
);
    AST_WAKE_ON_DOM: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_flag) |-> $past(bus_sync)); // R1

    AST_RX_HIGH_IDLE: assert property (@(posedge clk) disable iff (rst)
        !wake_flag |-> rx_out); // R5

    AST_RX_TRACKS_BUS: assert property (@(posedge clk) disable iff (rst)
        wake_flag |-> (rx_out == !bus_sync)); // R6

    AST_WAKE_HELD: assert property (@(posedge clk) disable iff (rst)
        (enable && wake_flag) |=> wake_flag); // R7

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!wake_flag && rx_out)); // R8
endmodule

bind wake_pattern_detector bwd_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (stby_en),
    .bus_sync  (bus_s),
    .wake_flag (wake_flag),
    .rx_out    (rx_out)
);

// File: tb/tb_wake_pattern_detector.sv
module tb_wake_pattern_detector;
    localparam int CLK_PERIOD = 10;
    localparam int F   = 4;
    localparam int TMO = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stby_en = 1'b0;
    logic bus_dom_raw = 1'b0;
    logic wake_flag, rx_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string tag;
        logic  exp_wake;
        logic  exp_rx;
    } item_t;
    item_t q[$];
    event sb_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    wake_pattern_detector #(.FILT_CYC(F), .TMO_CYC(TMO), .SYNC_STAGES(2)) dut (
        .clk         (clk),
        .rst         (rst),
        .stby_en     (stby_en),
        .bus_dom_raw (bus_dom_raw),
        .wake_flag   (wake_flag),
        .rx_out      (rx_out)
    );

    // Monitor: pops expected items and compares against the ports.
    initial begin
        forever begin
            @(sb_ev);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (wake_flag !== it.exp_wake || rx_out !== it.exp_rx) begin
                    errors++;
                    $display("FAIL %s: wake=%b rx=%b expected wake=%b rx=%b",
                             it.tag, wake_flag, rx_out, it.exp_wake, it.exp_rx);
                end
            end
        end
    end

    task automatic expect_out(input string tag, input logic w, input logic r);
        item_t it;
        it.tag = tag; it.exp_wake = w; it.exp_rx = r;
        q.push_back(it);
        -> sb_ev;
    endtask

    task automatic hold(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_dom_raw = v;
        end
    endtask

    task automatic pattern(input int d1, input int r, input int d2);
        hold(1'b1, d1);
        hold(1'b0, r);
        hold(1'b1, d2);
        hold(1'b0, 4);
    endtask

    task automatic rearm();
        @(negedge clk);
        stby_en = 1'b0;
        bus_dom_raw = 1'b0;
        hold(1'b0, 4);
        stby_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_out("R5 reset state", 1'b0, 1'b1);
        stby_en = 1'b1;
        hold(1'b0, 3);

        // Minimal valid pattern; rx stays high during the first dominant phase.
        hold(1'b1, F);
        expect_out("R5 rx high while dominant before wake", 1'b0, 1'b1);
        hold(1'b0, F);
        hold(1'b1, F);
        hold(1'b0, 4);
        expect_out("R2 third phase of exactly F samples wakes", 1'b1, 1'b1);

        // Receive output follows the bus after wake.
        hold(1'b1, 3);
        expect_out("R6 rx low on dominant after wake", 1'b1, 1'b0);
        hold(1'b0, 3);
        expect_out("R6 rx high on recessive after wake", 1'b1, 1'b1);
        hold(1'b1, 40);
        hold(1'b0, 3);
        expect_out("R7 wake held through bus activity", 1'b1, 1'b1);

        // Disable clears the latch after one edge.
        @(negedge clk);
        stby_en = 1'b0;
        bus_dom_raw = 1'b1;
        @(negedge clk);
        @(negedge clk);
        expect_out("R8 disable clears wake and forces rx high", 1'b0, 1'b1);
        hold(1'b0, 3);
        pattern(F, F, F);
        expect_out("R8 valid pattern ignored while disabled", 1'b0, 1'b1);
        rearm();

        pattern(F, F, F - 1);
        expect_out("R2 third phase of F-1 samples rejected", 1'b0, 1'b1);
        rearm();

        pattern(F - 1, F, F);
        expect_out("R3 short first phase discards progress", 1'b0, 1'b1);
        rearm();

        pattern(F, F - 1, F);
        expect_out("R3 short recessive phase discards progress", 1'b0, 1'b1);
        rearm();

        hold(1'b1, 60);
        hold(1'b0, 4);
        expect_out("R1 single long dominant gives no wake", 1'b0, 1'b1);
        rearm();

        // Short gap, then the dominant starts a new attempt that completes.
        hold(1'b1, F);
        hold(1'b0, F - 1);
        pattern(F, F, F);
        expect_out("R4 new attempt after short gap wakes", 1'b1, 1'b1);
        rearm();

        // Last dominant sample at index 19 (< TMO): accepted.
        pattern(6, 10, F);
        expect_out("R9 last sample at TMO-1 wakes", 1'b1, 1'b1);
        rearm();

        // Last dominant sample at index 20 (= TMO): abandoned.
        pattern(6, 11, F);
        expect_out("R9 last sample at TMO times out", 1'b0, 1'b1);
        rearm();

        // R4: restarted attempt, window counted from the new dominant sample.
        hold(1'b1, 6);
        hold(1'b0, F - 1);
        pattern(6, 10, F);
        expect_out("R4 window restarts with new attempt", 1'b1, 1'b1);

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule